// File: doc/BRIEF.md
# Serviceable Watchdog Timer with Programmable Reload

This block guards a processor's start-up and steady-state operation. A counter advances at a slow rate derived from the system clock, selectable between two division ratios. Software must strobe a service input before the counter wraps. Each service loads the counter's upper bits from an 8-bit reload field, so the monitored interval can be shortened. If the counter is allowed to wrap, the block raises an internal reset request and pulls an active-low reset pin for a fixed number of clocks. It then returns itself to its power-up state.

The watchdog is always running after reset. Early boot code may switch it off with a disable strobe. That permission ends for good once the end-of-initialization strobe arrives, and it is only restored by a reset, either external or self-generated. Control arrives as single-cycle strobes and level fields with no register wrapper.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, rst_req_o is 0 and rst_out_n_o is 1. The watchdog is enabled and disabling is still permitted.
- R2: While enabled, the CNT_W-bit counter advances once every DIV_LO clocks when div_sel_i is 0, and once every DIV_HI clocks when div_sel_i is 1.
- R3: A service strobe loads reload_i into the top RLD_W bits of the counter and clears the lower bits and the prescaler. The next wrap then lands exactly (2^CNT_W − reload·2^(CNT_W−RLD_W))·div clock edges after the edge that captured the strobe.
- R4: With no service and div_sel_i = 0, the first wrap after reset occurs on the 2^CNT_W·DIV_LO-th clock edge after reset release.
- R5: A disable strobe before any end-of-initialization strobe stops the watchdog, so no reset request is ever raised afterwards. This includes a disable that arrives in the same cycle as the end-of-initialization strobe, and one that arrives in the cycle the counter would wrap.
- R6: Once an end-of-initialization strobe has been captured, disable strobes have no effect, and the wrap still happens on schedule.
- R7: A wrap sets rst_req_o to 1 and rst_out_n_o to 0 from the clock edge of the wrap, for exactly PULSE_LEN cycles. During that time rst_out_n_o is always the complement of rst_req_o.
- R8: When the pulse ends, the counter, prescaler, enable and lock are back at their reset values. The next unserviced wrap follows the R4 interval, and a disable strobe is honoured again.
- R9: A service strobe captured on the same edge as a wrap takes priority. No reset request is raised, and the counter is loaded as in R3.
- R10: Service, disable and end-of-initialization strobes that arrive while the reset pulse is active are ignored. The pulse keeps its length, and the following interval is the R4 interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| service_i | input | 1 | Service strobe, one cycle |
| disable_i | input | 1 | Disable request strobe |
| einit_i | input | 1 | End-of-initialization strobe; locks out disabling |
| div_sel_i | input | 1 | Prescaler select: 0 = DIV_LO, 1 = DIV_HI |
| reload_i | input | RLD_W | Value loaded into the counter's upper bits on service |
| rst_req_o | output | 1 | Internal reset request, active high |
| rst_out_n_o | output | 1 | Reset pin, active low |

## Verification
The bench builds the block with CNT_W = 12, RLD_W = 8, DIV_LO = 2, DIV_HI = 128 and PULSE_LEN = 5. This keeps the reload field at full width above a 4-bit lower part. The longest divide-by-2 interval is then 8192 clocks, so unserviced timeouts, post-pulse timeouts and divide-by-128 intervals all fit in a short run. Services are placed part-way through the lower bits and through a prescaler period, which exposes any failure to clear them. Exact edges for wraps, same-edge collisions and pulse boundaries are checked.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef struct packed {
      logic en;
      logic lock;
      logic busy;
   } wdg_state_t;

   function automatic int unsigned wdg_pulse_w(input int unsigned len);
      return $clog2(len + 1);
   endfunction
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
   parameter int unsigned DIV_LO = 2,
   parameter int unsigned DIV_HI = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic sel,
   output logic tick
);
   localparam int unsigned PRE_W = $clog2(DIV_HI);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;

   generate
      if (DIV_LO == DIV_HI) begin : g_fixed
         assign lim = PRE_W'(DIV_HI - 1);
      end else begin : g_select
         assign lim = sel ? PRE_W'(DIV_HI - 1) : PRE_W'(DIV_LO - 1);
      end
   endgenerate

   assign tick = run && (pre_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (clr) begin
         pre_q <= '0;
      end else if (run) begin
         pre_q <= tick ? '0 : pre_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned RLD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [RLD_W-1:0] reload,
   input  logic             step,
   output logic             wrap
);
   localparam int unsigned LO_W = CNT_W - RLD_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   generate
      if (LO_W == 0) begin : g_full_load
         assign load_val = reload;
      end else begin : g_high_load
         assign load_val = {reload, {LO_W{1'b0}}};
      end
   endgenerate

   assign wrap = step && (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
   import wdg_pkg::*;
#(
   parameter int unsigned PULSE_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic service_i,
   input  logic disable_i,
   input  logic einit_i,
   input  logic wrap_i,
   output logic run_o,
   output logic load_o,
   output logic clr_o,
   output logic busy_o
);
   localparam int unsigned PW = wdg_pulse_w(PULSE_LEN);

   wdg_state_t     st_q;
   logic [PW-1:0]  pcnt_q;
   logic           svc_ok;
   logic           dis_ok;
   logic           fire;

   assign svc_ok = service_i && st_q.en && !st_q.busy;
   assign dis_ok = disable_i && st_q.en && !st_q.lock && !st_q.busy;
   assign fire   = wrap_i && !svc_ok && !dis_ok;

   assign run_o  = st_q.en && !st_q.busy;
   assign load_o = svc_ok;
   assign clr_o  = fire || st_q.busy;
   assign busy_o = st_q.busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '{en: 1'b1, lock: 1'b0, busy: 1'b0};
         pcnt_q <= '0;
      end else if (st_q.busy) begin
         if (pcnt_q == '0) begin
            st_q.busy <= 1'b0;
         end else begin
            pcnt_q <= pcnt_q - 1'b1;
         end
      end else if (fire) begin
         st_q   <= '{en: 1'b1, lock: 1'b0, busy: 1'b1};
         pcnt_q <= PW'(PULSE_LEN - 1);
      end else begin
         if (dis_ok) begin
            st_q.en <= 1'b0;
         end
         if (einit_i) begin
            st_q.lock <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned RLD_W     = 8,
   parameter int unsigned DIV_LO    = 2,
   parameter int unsigned DIV_HI    = 128,
   parameter int unsigned PULSE_LEN = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             service_i,
   input  logic             disable_i,
   input  logic             einit_i,
   input  logic             div_sel_i,
   input  logic [RLD_W-1:0] reload_i,
   output logic             rst_req_o,
   output logic             rst_out_n_o
);
   logic run;
   logic load;
   logic clr;
   logic tick;
   logic wrap;
   logic busy;

   initial begin
      assert (CNT_W >= RLD_W && RLD_W >= 1) else $error("CNT_W must cover RLD_W");
      assert (DIV_LO >= 2 && DIV_HI >= DIV_LO) else $error("divider range invalid");
      assert (PULSE_LEN >= 1) else $error("PULSE_LEN must be at least 1");
   end

   wdg_ctrl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .service_i(service_i), .disable_i(disable_i), .einit_i(einit_i),
      .wrap_i(wrap),
      .run_o(run), .load_o(load), .clr_o(clr), .busy_o(busy)
   );

   wdg_prescale #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
      .clk(clk), .rst_n(rst_n),
      .clr(clr || load), .run(run), .sel(div_sel_i),
      .tick(tick)
   );

   wdg_counter #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr(clr), .load(load), .reload(reload_i), .step(tick),
      .wrap(wrap)
   );

   assign rst_req_o   = busy;
   assign rst_out_n_o = ~busy;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
   parameter int unsigned PULSE_LEN = 8
) (
   input logic clk,
   input logic rst_n,
   input logic service_i,
   input logic disable_i,
   input logic einit_i,
   input logic rst_req_o,
   input logic rst_out_n_o
);
   logic [15:0] run_len;
   logic        ck_lock;
   logic        ck_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '0;
         ck_lock <= 1'b0;
         ck_off  <= 1'b0;
      end else begin
         run_len <= rst_req_o ? run_len + 1'b1 : '0;
         if (rst_req_o) begin
            ck_lock <= 1'b0;
         end else begin
            if (einit_i) ck_lock <= 1'b1;
            if (disable_i && !ck_lock) ck_off <= 1'b1;
         end
      end
   end

   AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> (run_len < 16'(PULSE_LEN)));                 // R7
   AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_req_o) |-> (run_len == 16'(PULSE_LEN)));         // R7
   AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> !rst_out_n_o);                               // R7
   AST_SERVICE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (service_i && !rst_req_o) |=> !rst_req_o);                 // R9
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ck_off |-> !rst_req_o);                                    // R5
endmodule

bind svc_watchdog wdg_checker #(.PULSE_LEN(PULSE_LEN)) u_wdg_chk (
   .clk(clk), .rst_n(rst_n), .service_i(service_i), .disable_i(disable_i),
   .einit_i(einit_i), .rst_req_o(rst_req_o), .rst_out_n_o(rst_out_n_o)
);

// File: tb/svc_watchdog_bench.sv
module svc_watchdog_bench;
   localparam int unsigned CW = 12;
   localparam int unsigned RW = 8;
   localparam int unsigned DLO = 2;
   localparam int unsigned DHI = 128;
   localparam int unsigned PL = 5;
   localparam int unsigned FULL = (1 << CW) * DLO;

   typedef struct packed {
      logic        sel;
      logic [7:0]  rld;
      logic [15:0] at;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{1'b0, 8'hFF, 16'd1},
      '{1'b0, 8'h80, 16'd3},
      '{1'b1, 8'hFF, 16'd5},
      '{1'b0, 8'hF0, 16'd2},
      '{1'b1, 8'hFE, 16'd70},
      '{1'b0, 8'h00, 16'd7}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic service_i = 1'b0;
   logic disable_i = 1'b0;
   logic einit_i = 1'b0;
   logic div_sel_i = 1'b0;
   logic [RW-1:0] reload_i = '0;
   logic rst_req_o;
   logic rst_out_n_o;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   svc_watchdog #(.CNT_W(CW), .RLD_W(RW), .DIV_LO(DLO), .DIV_HI(DHI), .PULSE_LEN(PL))
   u_svc_watchdog (
      .clk(clk), .rst_n(rst_n), .service_i(service_i), .disable_i(disable_i),
      .einit_i(einit_i), .div_sel_i(div_sel_i), .reload_i(reload_i),
      .rst_req_o(rst_req_o), .rst_out_n_o(rst_out_n_o)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; service_i = 0; disable_i = 0; einit_i = 0;
      edges(3);
      rst_n = 1'b1;
   endtask

   // drive strobes so that edge k (counted from now) captures them
   task automatic strobe_at(input int k, input logic s, input logic d, input logic e);
      if (k > 1) edges(k - 1);
      service_i = s; disable_i = d; einit_i = e;
      edges(1);
      service_i = 0; disable_i = 0; einit_i = 0;
   endtask

   // expect rst_req_o to rise on the t-th edge from now
   task automatic expect_wrap(input string tag, input int t);
      edges(t - 1);
      chk({tag, " before wrap"}, rst_req_o, 0);
      edges(1);
      chk({tag, " at wrap"}, rst_req_o, 1);
   endtask

   task automatic measure_pulse(input string tag, input logic poke);
      int len = 0;
      int pin_bad = 0;
      while (rst_req_o && len < 100) begin
         if (rst_out_n_o !== 1'b0) pin_bad++;
         len++;
         service_i = poke; disable_i = poke; einit_i = poke;
         edges(1);
      end
      service_i = 0; disable_i = 0; einit_i = 0;
      chk({tag, " pulse length"}, len, PL);
      chk({tag, " pin low during pulse"}, pin_bad, 0);
      chk({tag, " pin released"}, rst_out_n_o, 1);
   endtask

   initial begin
      #(1_900_000 * 10);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset();
      chk("R1 rst_req after reset", rst_req_o, 0);
      chk("R1 rst_out_n after reset", rst_out_n_o, 1);

      // R2 R3 table of reload / divider vectors
      foreach (VEC[i]) begin
         int div;
         int t;
         div = VEC[i].sel ? DHI : DLO;
         t = ((1 << CW) - int'(VEC[i].rld) * (1 << (CW - RW))) * div;
         do_reset();
         div_sel_i = VEC[i].sel;
         reload_i = VEC[i].rld;
         strobe_at(int'(VEC[i].at), 1, 0, 0);
         expect_wrap($sformatf("R3 R2 vec%0d", i), t);
         measure_pulse($sformatf("R7 vec%0d", i), 0);
      end
      div_sel_i = 0;

      // R4 default timeout, then R7, then R8 repeat and lock cleared
      do_reset();
      expect_wrap("R4 default", FULL);
      measure_pulse("R7 default", 0);
      expect_wrap("R8 after pulse", FULL);
      measure_pulse("R7 second", 0);
      strobe_at(1, 0, 1, 0);
      edges(FULL + 50);
      chk("R8 disable honoured after pulse", rst_req_o, 0);

      // R5 disable in same cycle as end-of-init
      do_reset();
      strobe_at(1, 0, 1, 1);
      edges(FULL + 50);
      chk("R5 disabled no reset", rst_req_o, 0);

      // R5 disable on the wrap edge
      do_reset();
      strobe_at(FULL, 0, 1, 0);
      chk("R5 disable at wrap edge", rst_req_o, 0);
      edges(FULL + 50);
      chk("R5 stays quiet", rst_req_o, 0);

      // R6 disable after end-of-init ignored
      do_reset();
      strobe_at(1, 0, 0, 1);
      strobe_at(2, 0, 1, 0);
      expect_wrap("R6 locked disable", FULL - 3);
      measure_pulse("R7 after R6", 0);

      // R9 service on the wrap edge
      do_reset();
      reload_i = 8'hF0;
      strobe_at(FULL, 1, 0, 0);
      chk("R9 no reset on collision", rst_req_o, 0);
      expect_wrap("R9 reload after collision", ((1 << CW) - 240 * 16) * DLO);
      measure_pulse("R7 after R9", 0);

      // R10 strobes during pulse ignored
      do_reset();
      reload_i = 8'hFF;
      expect_wrap("R10 setup", FULL);
      measure_pulse("R10 strobes in pulse", 1);
      expect_wrap("R10 next interval default", FULL);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule